// File: doc/BRIEF.md
# Scan-Configured Routing Connection Box

This block connects two routing channels to the input pins of a logic block. Each channel carries four one-way wires, seen here as `trk_a` and `trk_b`. Each of the two output pins can reach a fixed, sparse subset of these wires. Pin 0 reaches the even positions of either channel and pin 1 reaches the odd positions. A small code held in configuration flops picks which of those wires drives each pin. The pin path itself is purely combinational, so once the box is configured a change on a wire reaches the pin with no clock edge.

The configuration flops form a serial chain clocked by `scan_clk`. When `scan_enable` is high, one bit enters per rising edge. `scan_out` always shows the oldest bit in the chain, which lets several boxes be daisy-chained and lets the loaded bits be read back by shifting again. An asynchronous active-low reset clears every configuration bit. The reset is released in step with `scan_clk`, two edges after `rst_n` rises.

Top module: `cbox_route`

## Requirements
- R1: While reset is asserted, every configuration bit is 0 at once, with no clock edge needed. In that state `pin_o[0]` follows `trk_a[0]`, `pin_o[1]` follows `trk_a[1]`, and `scan_out` is 0.
- R2: On each rising `scan_clk` edge with `scan_enable` high, the chain advances by one position and takes `scan_in` as its newest bit. `scan_out` shows the bit that entered four shifts earlier.
- R3: With `scan_enable` low, rising edges change nothing: the chain, `scan_out` and the pin selections keep their values whatever `scan_in` does.
- R4: Pin 0 follows its code as follows: code 0 selects `trk_a[0]`, code 1 selects `trk_b[0]`, code 2 selects `trk_a[2]`, and code 3 selects `trk_b[2]`.
- R5: Pin 1 follows its code as follows: code 0 selects `trk_a[1]`, code 1 selects `trk_b[1]`, code 2 selects `trk_a[3]`, and code 3 selects `trk_b[3]`.
- R6: The configuration is a list of four bits in this order: pin 0 code MSB, pin 0 code LSB, pin 1 code MSB, pin 1 code LSB. The last list bit is shifted in first. After four shifts, list bit j is the bit that entered at shift 4-j.
- R7: Once configured, a change on `trk_a` or `trk_b` reaches `pin_o` in the same cycle, without any `scan_clk` edge.
- R8: Four further shifts bring the loaded list out on `scan_out` in the order list bit 3, 2, 1, 0. Each bit is visible before the edge that moves it out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| scan_enable | input | 1 | Shift enable for the chain |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Oldest chain bit, for chaining and readback |
| trk_a | input | 4 | Wires of the first routing channel |
| trk_b | input | 4 | Wires of the second routing channel |
| pin_o | output | 2 | Selected wire for each logic-block pin |

## Verification
The hardest corner is the bit layout. A design that swapped the two fields, or the MSB and LSB within a field, would route a wire of the wrong parity or the wrong channel. The bench exposes this by loading asymmetric codes, such as pin 0 on code 2 and pin 1 on code 1, against track patterns where only the intended wire is high. The hold behaviour is checked by toggling `scan_in` with the enable low; a chain that ignored the enable would drift and change `pin_o`. A reset driven in the middle of a cycle must clear the selections at once, and a synchronous clear would be caught there. The readback order is checked bit by bit, so a chain that tapped the wrong end would show up as a reversed sequence on `scan_out`.

// File: rtl/cbox_pkg.sv
package cbox_pkg;
  localparam int CB_TRACK_W_DEF = 4;
  localparam int CB_PINS_DEF    = 2;

  // code = {group index, channel}; channel 0 is trk_a, 1 is trk_b
  function automatic int cb_sel_width(input int track_w, input int pins);
    return 1 + $clog2(track_w / pins);
  endfunction
endpackage

// File: rtl/cbox_rst_sync.sv
module cbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cbox_cfg_chain.sv
module cbox_cfg_chain #(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] bits_q,
  output logic           dout
);
  logic [LEN-1:0] bits_d;

  // newest bit at index 0, oldest at LEN-1
  always_comb begin
    bits_d = {bits_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits_q <= '0;
    else if (shift_en) bits_q <= bits_d;
  end

  assign dout = bits_q[LEN-1];
endmodule

// File: rtl/cbox_pin_mux.sv
module cbox_pin_mux #(
  parameter int TRACK_W  = 4,
  parameter int NUM_PINS = 2,
  parameter int PIN      = 0,
  parameter int SEL_W    = 2
) (
  input  logic [TRACK_W-1:0] trk_a,
  input  logic [TRACK_W-1:0] trk_b,
  input  logic [SEL_W-1:0]   sel,
  output logic               pin
);
  localparam int GROUPS = TRACK_W / NUM_PINS;
  localparam int NCAND  = 2 * GROUPS;

  logic [NCAND-1:0] cand;

  // candidate 2g is channel a, 2g+1 channel b, both at wire PIN + NUM_PINS*g
  for (genvar g = 0; g < GROUPS; g++) begin : g_cand
    assign cand[2*g]   = trk_a[PIN + NUM_PINS*g];
    assign cand[2*g+1] = trk_b[PIN + NUM_PINS*g];
  end

  assign pin = cand[sel];
endmodule

// File: rtl/cbox_route.sv
module cbox_route #(
  parameter int TRACK_W  = cbox_pkg::CB_TRACK_W_DEF,
  parameter int NUM_PINS = cbox_pkg::CB_PINS_DEF
) (
  input  logic                scan_clk,
  input  logic                rst_n,
  input  logic                scan_enable,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [TRACK_W-1:0]  trk_a,
  input  logic [TRACK_W-1:0]  trk_b,
  output logic [NUM_PINS-1:0] pin_o
);
  localparam int SEL_W = cbox_pkg::cb_sel_width(TRACK_W, NUM_PINS);
  localparam int CHAIN = NUM_PINS * SEL_W;

  logic             rst_sync_n;
  logic [CHAIN-1:0] cfg_q;

  cbox_rst_sync u_rst (
    .clk        (scan_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbox_cfg_chain #(.LEN(CHAIN)) u_chain (
    .clk      (scan_clk),
    .rst_n    (rst_sync_n),
    .shift_en (scan_enable),
    .din      (scan_in),
    .bits_q   (cfg_q),
    .dout     (scan_out)
  );

  // field of pin p: cfg_q[p*SEL_W] is its MSB, cfg_q[p*SEL_W+SEL_W-1] its LSB
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] sel;
    for (genvar b = 0; b < SEL_W; b++) begin : g_bit
      assign sel[SEL_W-1-b] = cfg_q[p*SEL_W + b];
    end
    cbox_pin_mux #(
      .TRACK_W  (TRACK_W),
      .NUM_PINS (NUM_PINS),
      .PIN      (p),
      .SEL_W    (SEL_W)
    ) u_mux (
      .trk_a (trk_a),
      .trk_b (trk_b),
      .sel   (sel),
      .pin   (pin_o[p])
    );
  end
endmodule

// File: rtl/cbox_route_chk.sv
module cbox_route_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_enable,
  input logic       scan_in,
  input logic       scan_out,
  input logic [3:0] cfg_q,
  input logic [3:0] trk_a,
  input logic [3:0] trk_b,
  input logic [1:0] pin_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (cfg_q == 4'b0000 && !scan_out));

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_enable |=> cfg_q[0] == $past(scan_in));

  // R2
  shift_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_enable |=> scan_out == $past(cfg_q[2]));

  // R3
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_enable |=> $stable(cfg_q) && $stable(scan_out));

  // R4
  pin0_code2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0] && !cfg_q[1]) |-> pin_o[0] == trk_a[2]);

  // R5
  pin1_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[2] && cfg_q[3]) |-> pin_o[1] == trk_b[3]);
endmodule

bind cbox_route cbox_route_chk chk_i (
  .clk         (scan_clk),
  .rst_n       (rst_sync_n),
  .scan_enable (scan_enable),
  .scan_in     (scan_in),
  .scan_out    (scan_out),
  .cfg_q       (cfg_q),
  .trk_a       (trk_a),
  .trk_b       (trk_b),
  .pin_o       (pin_o)
);

// File: tb/cbox_route_tb.sv
module cbox_route_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       scan_enable = 1'b0;
  logic       scan_in = 1'b0;
  logic       scan_out;
  logic [3:0] trk_a = 4'h0;
  logic [3:0] trk_b = 4'h0;
  logic [1:0] pin_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit mq[$];   // model chain, index j = list bit j
  bit watch_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbox_route dut_i (
    .scan_clk    (clk),
    .rst_n       (rst_n),
    .scan_enable (scan_enable),
    .scan_in     (scan_in),
    .scan_out    (scan_out),
    .trk_a       (trk_a),
    .trk_b       (trk_b),
    .pin_o       (pin_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pin(input int p);
    int code;
    int idx;
    code = mq[2*p] * 2 + mq[2*p+1];
    idx  = p + 2 * (code >> 1);
    return (code & 1) ? trk_b[idx] : trk_a[idx];
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mq = '{0, 0, 0, 0};
    else if (scan_enable) begin
      mq.push_front(scan_in);
      void'(mq.pop_back());
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (watch_on) begin
      chk("R2", "scan_out", scan_out, mq[3]);
      chk("R4", "pin_o[0]", pin_o[0], exp_pin(0));
      chk("R5", "pin_o[1]", pin_o[1], exp_pin(1));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // lst[j] is list bit j; bit 3 goes in first (R6)
  task automatic load(input logic [3:0] lst);
    for (int j = 3; j >= 0; j--) begin
      scan_enable = 1'b1;
      scan_in     = lst[j];
      tick();
    end
    scan_enable = 1'b0;
    scan_in     = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #3;
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    mq = '{0, 0, 0, 0};
    #2;
    rst_n = 1'b0;
    trk_a = 4'b0011;
    trk_b = 4'b1100;
    #1;
    // R1: immediate clear under reset
    chk("R1", "pin0 in reset", pin_o[0], 1);
    chk("R1", "pin1 in reset", pin_o[1], 1);
    chk("R1", "scan_out in reset", scan_out, 0);
    #4;
    rst_n = 1'b1;
    repeat (4) tick();
    watch_on = 1'b1;

    // R4 R5: every code on both pins against several track patterns
    for (int c = 0; c < 4; c++) begin
      load({c[1], c[0], 1'b0, 1'b0} ^ {2'b00, 2'(3 - c)});
      for (int t = 0; t < 6; t++) begin
        trk_a = 4'(t * 5 + c);
        trk_b = ~4'(t * 3 + c);
        tick();
      end
    end

    // R6: pin0 code 2, pin1 code 1 -> list 1,0,0,1
    load(4'b1001);
    trk_a = 4'b0100;
    trk_b = 4'b0010;
    #1;
    chk("R6", "pin0 from trk_a[2]", pin_o[0], 1);
    chk("R6", "pin1 from trk_b[1]", pin_o[1], 1);
    trk_a = 4'b1011;
    trk_b = 4'b1101;
    #1;
    chk("R6", "pin0 low wire", pin_o[0], 0);
    chk("R6", "pin1 low wire", pin_o[1], 0);

    // R7: track change mid-cycle reaches pins without an edge
    trk_a = 4'b0100;
    #1;
    chk("R7", "pin0 follows trk_a[2]", pin_o[0], 1);
    trk_b = 4'b0010;
    #1;
    chk("R7", "pin1 follows trk_b[1]", pin_o[1], 1);
    tick();

    // R3: scan_in toggles with enable low
    for (int k = 0; k < 6; k++) begin
      scan_in = k[0];
      tick();
    end
    scan_in = 1'b0;
    chk("R3", "pin0 held", pin_o[0], 1);
    chk("R3", "pin1 held", pin_o[1], 1);
    chk("R3", "scan_out held", scan_out, 1);

    // R8: readback order 3,2,1,0 of list 1,0,1,1 -> lst = 4'b1101
    load(4'b1101);
    for (int j = 3; j >= 0; j--) begin
      @(negedge clk);
      chk("R8", "readback bit", scan_out, (4'b1101 >> j) & 1);
      scan_enable = 1'b1;
      scan_in     = 1'b0;
      tick();
    end
    scan_enable = 1'b0;
    chk("R8", "chain emptied", scan_out, 0);

    // R1: mid-run reset clears configuration at once
    load(4'b1111);
    trk_a = 4'b0011;
    trk_b = 4'b0000;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1", "pin0 after async reset", pin_o[0], 1);
    chk("R1", "pin1 after async reset", pin_o[1], 1);
    #3;
    do_reset();
    repeat (2) tick();

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule